// File: doc/BRIEF.md
# Gated frequency counter

This block measures the frequency of one of several internal clock sources. It counts the rising edges of the chosen source over a gate window. A 1 ms reference tick times the window. The rate in kHz is the count divided by the window length in milliseconds. Control comes from register fields: an enable, a 3-bit source code, a 2-bit window code and a start bit. The start bit is cleared by the `start_clr` strobe at the end of each run. The 16-bit result is presented as a low byte and a high byte. These two bytes change only when a measurement completes.

The control is one state machine with five states:

- **ST_IDLE:** waits for a rising edge of `start` while `en` is high.
  - Transition *trigger*: ST_IDLE to ST_ARM. The source and window codes are captured at this point.
- **ST_ARM:** waits for the next reference tick, so that the window starts on a tick boundary.
  - Transition *open*: ST_ARM to ST_GATE on a tick. The counter clears and the tick budget loads.
- **ST_GATE:** counts source edges and spends one unit of budget on each tick.
  - Transition *close*: ST_GATE to ST_LATCH on the tick that uses up the budget.
- **ST_LATCH:** copies the count into the result and pulses `start_clr`.
  - Transition *done*: ST_LATCH to ST_IDLE.
- **ST_CANCEL:** pulses `start_clr` without touching the result.
  - Transition *abort*: ST_ARM or ST_GATE to ST_CANCEL when `en` falls.
  - Transition *release*: ST_CANCEL to ST_IDLE.

Top module: `freq_gate_counter`

## Requirements
- R1: While reset is asserted, `busy` and `start_clr` are 0 and the result reads 0.
- R2: A 0-to-1 change of `start` sampled in ST_IDLE with `en` high sets `busy` from the next cycle. The window opens at the first `ms_tick` after that.
- R3: Window code 0 gives 4 ticks, code 1 gives 8 ticks, code 2 gives 32 ticks and code 3 gives 64 ticks. Edges count from the cycle after the opening tick through the cycle of the closing tick.
- R4: Source codes 1 and 7 select `src_if`. Codes 2 and 3 select `src_psc`. Codes 4 and 5 select `src_f0`. Codes 0 and 6 select nothing, so the count is 0.
- R5: `count_lo` holds result bits 7:0 and `count_hi` holds bits 15:8. The result changes only at window close, so a read during a run returns the previous result.
- R6: The count stops at 0xFFFF instead of wrapping.
- R7: `start_clr` is a one-cycle pulse in the cycle after the closing tick. In the next cycle `busy` is 0 and the new result is visible.
- R8: A rising edge of `start` while `busy` is high, or while `en` is low, starts nothing.
- R9: If `en` goes low during ST_ARM or ST_GATE, the run is abandoned. The result keeps its old value, `start_clr` pulses once and `busy` falls.
- R10: The source and window codes are taken at the trigger. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable field |
| src_sel | input | 3 | Source code field |
| gate_sel | input | 2 | Window code field |
| start | input | 1 | Start bit; its rising edge triggers a run |
| src_if | input | 1 | IF clock level, already synchronised |
| src_psc | input | 1 | Prescaler output level, already synchronised |
| src_f0 | input | 1 | f0 oscillator level, already synchronised |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| count_lo | output | 8 | Result bits 7:0 |
| count_hi | output | 8 | Result bits 15:8 |
| busy | output | 1 | High from trigger until result is latched or run abandoned |
| start_clr | output | 1 | One-cycle strobe that clears the start bit |

## Verification
The assertions assume the following about the inputs:
- The source levels and `ms_tick` are already synchronous to `clk`.
- `ms_tick` is a single-cycle pulse.
- `start` behaves like a register bit, so a new trigger needs a fresh 0-to-1 change.

The stimulus drives every input at the falling clock edge. The sources are counter-derived square waves whose periods divide the window length, so each expected count follows exactly from the window length. The tick period is changed only between runs. For the saturation run the tick phase is pulled close to the trigger, so the arm wait stays short.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    localparam int SRC_CNT = 3;
    localparam int LEN_W   = 7;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_GATE   = 3'd2,
        ST_LATCH  = 3'd3,
        ST_CANCEL = 3'd4
    } fgc_state_e;

    // window length in reference ticks for each 2-bit window code
    function automatic logic [LEN_W-1:0] gate_ticks(input logic [1:0] code);
        logic [LEN_W-1:0] n;
        unique case (code)
            2'd0:    n = LEN_W'(4);
            2'd1:    n = LEN_W'(8);
            2'd2:    n = LEN_W'(32);
            default: n = LEN_W'(64);
        endcase
        return n;
    endfunction

    // one-hot pick over {f0, prescaler, IF}; all zero for unused codes
    function automatic logic [SRC_CNT-1:0] src_onehot(input logic [2:0] code);
        logic [SRC_CNT-1:0] m;
        unique case (code)
            3'd1, 3'd7: m = 3'b001;
            3'd2, 3'd3: m = 3'b010;
            3'd4, 3'd5: m = 3'b100;
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fgc_src_sel.sv
module fgc_src_sel
    import fgc_pkg::*;
(
    input  logic [2:0]         code,
    input  logic [SRC_CNT-1:0] lvl,
    output logic               sel_lvl
);

    logic [SRC_CNT-1:0] pick;
    logic [SRC_CNT-1:0] term;

    assign pick = src_onehot(code);

    genvar i;
    generate
        for (i = 0; i < SRC_CNT; i++) begin : g_term
            assign term[i] = pick[i] & lvl[i];
        end
    endgenerate

    assign sel_lvl = |term;

endmodule

// File: rtl/fgc_edge_det.sv
module fgc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;

endmodule

// File: rtl/fgc_sat_counter.sv
module fgc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (clr)                cnt <= '0;
        else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
    end

    // R6
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !clr) |=> cnt == TOP);

endmodule

// File: rtl/fgc_gate_timer.sv
module fgc_gate_timer #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] len,
    input  logic          step,
    output logic          last
);

    logic [LW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    left <= '0;
        else if (load)                 left <= len;
        else if (step && left != '0)   left <= left - 1'b1;
    end

    assign last = (left == LW'(1));

    // R3
    step_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> left != '0);

endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
    import fgc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [2:0]         src_sel,
    input  logic [1:0]         gate_sel,
    input  logic               start,
    input  logic               src_if,
    input  logic               src_psc,
    input  logic               src_f0,
    input  logic               ms_tick,
    output logic [CNT_W/2-1:0] count_lo,
    output logic [CNT_W/2-1:0] count_hi,
    output logic               busy,
    output logic               start_clr
);

    localparam int HALF = CNT_W / 2;

    fgc_state_e        st, st_nx;
    logic              start_q;
    logic              trig;
    logic [2:0]        src_q;
    logic [1:0]        gate_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  result;
    logic              sel_lvl;
    logic              rise;
    logic              gate_open;
    logic              gate_step;
    logic              gate_last;
    logic              cnt_inc;

    assign trig = start & ~start_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (en && trig)                 st_nx = ST_ARM;
            ST_ARM:    if (!en)                        st_nx = ST_CANCEL;
                       else if (ms_tick)               st_nx = ST_GATE;
            ST_GATE:   if (!en)                        st_nx = ST_CANCEL;
                       else if (ms_tick && gate_last)  st_nx = ST_LATCH;
            ST_LATCH:                                  st_nx = ST_IDLE;
            ST_CANCEL:                                 st_nx = ST_IDLE;
            default:                                   st_nx = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        busy      = (st != ST_IDLE);
        start_clr = 1'b0;
        gate_open = 1'b0;
        gate_step = 1'b0;
        cnt_inc   = 1'b0;
        unique case (st)
            ST_ARM:    gate_open = en & ms_tick;
            ST_GATE: begin
                gate_step = en & ms_tick;
                cnt_inc   = en & rise;
            end
            ST_LATCH,
            ST_CANCEL: start_clr = 1'b1;
            default:   ;
        endcase
    end

    // capture of controls and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            src_q   <= '0;
            gate_q  <= 2'd1;
            result  <= '0;
        end else begin
            start_q <= start;
            if (st == ST_IDLE && en && trig) begin
                src_q  <= src_sel;
                gate_q <= gate_sel;
            end
            if (st == ST_LATCH) result <= cnt;
        end
    end

    fgc_src_sel u_sel (
        .code    (src_q),
        .lvl     ({src_f0, src_psc, src_if}),
        .sel_lvl (sel_lvl)
    );

    fgc_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sel_lvl),
        .rise  (rise)
    );

    fgc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (gate_open),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    fgc_gate_timer #(.LW(LEN_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gate_open),
        .len   (gate_ticks(gate_q)),
        .step  (gate_step),
        .last  (gate_last)
    );

    assign count_lo = result[HALF-1:0];
    assign count_hi = result[CNT_W-1:HALF];

    // R2
    trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en && start && !start_q) |=> busy);

    // R7
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !start_clr);

    // R7
    clr_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !busy);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_clr) |=> $stable({count_hi, count_lo}));

    // R9
    abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && busy && !start_clr) |=> start_clr);

endmodule

// File: tb/freq_gate_counter_bench.sv
`timescale 1ns/1ps
module freq_gate_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       start = 1'b0;
    logic [2:0] src_sel = 3'd1;
    logic [1:0] gate_sel = 2'd1;
    logic       src_if = 1'b0, src_psc = 1'b0, src_f0 = 1'b0, ms_tick = 1'b0;
    logic [7:0] count_lo, count_hi;
    logic       busy, start_clr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tick_per = 20;
    int tick_ctr = 0;
    bit tick_jump = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    freq_gate_counter u_freq_gate_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .gate_sel(gate_sel),
        .start(start), .src_if(src_if), .src_psc(src_psc), .src_f0(src_f0),
        .ms_tick(ms_tick), .count_lo(count_lo), .count_hi(count_hi),
        .busy(busy), .start_clr(start_clr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int res();
        return {count_hi, count_lo};
    endfunction

    // reference model state: 0 idle, 1 arm, 2 gate, 3 latch, 4 cancel
    int m_st = 0, m_cnt = 0, m_res = 0, m_left = 0, m_len = 8, m_src = 0;
    bit m_prev = 0, m_startq = 0;

    function automatic bit pick(input int s);
        case (s)
            1, 7:    return src_if;
            2, 3:    return src_psc;
            4, 5:    return src_f0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int win(input int g);
        case (g)
            0:       return 4;
            1:       return 8;
            2:       return 32;
            default: return 64;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_res = 0; m_left = 0; m_src = 0;
            m_prev = 0; m_startq = 0;
        end else begin
            bit lvl, rise, trig;
            lvl = pick(m_src);
            rise = lvl && !m_prev;
            m_prev = lvl;
            trig = start && !m_startq;
            m_startq = start;
            case (m_st)
                0: if (trig && en) begin m_st = 1; m_src = src_sel; m_len = win(gate_sel); end
                1: if (!en) m_st = 4;
                   else if (ms_tick) begin m_st = 2; m_cnt = 0; m_left = m_len; end
                2: if (!en) m_st = 4;
                   else begin
                       if (rise && m_cnt < 65535) m_cnt++;
                       if (ms_tick) begin
                           m_left--;
                           if (m_left == 0) m_st = 3;
                       end
                   end
                3: begin m_res = m_cnt; m_st = 0; end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison, then stimulus for sources and tick
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == (m_st != 0), "R2 busy vs model", busy, m_st != 0);
            check(start_clr == (m_st == 3 || m_st == 4), "R7 start_clr vs model",
                  start_clr, (m_st == 3 || m_st == 4));
            check(res() == m_res, "R5 result vs model", res(), m_res);
        end
        cyc = cyc + 1;
        src_if  = (cyc % 2) == 1;
        src_psc = ((cyc / 2) % 2) == 1;
        src_f0  = (cyc % 10) >= 5;
        if (tick_jump) begin tick_ctr = tick_per - 3; tick_jump = 1'b0; end
        if (tick_ctr >= tick_per - 1) begin tick_ctr = 0; ms_tick = 1'b1; end
        else begin tick_ctr++; ms_tick = 1'b0; end
        if (cyc > 199000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 199000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic go(input logic [2:0] s, input logic [1:0] g);
        @(negedge clk);
        src_sel = s; gate_sel = g; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int pulses);
        pulses = 0;
        for (int i = 0; i < 200000 && busy; i++) begin
            if (start_clr) pulses++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input logic [2:0] s, input logic [1:0] g, input int exp, input string tag);
        int p;
        go(s, g);
        wait_done(p);
        check(res() == exp, tag, res(), exp);
        check(p == 1, "R7 one clear pulse per run", p, 1);
    endtask

    initial begin
        int p, prev;
        repeat (3) @(negedge clk);
        check(!busy && !start_clr && res() == 0, "R1 reset state", res(), 0);
        rst_n = 1'b1; en = 1'b1;
        @(negedge clk);

        // tick period 20: IF gives 10 edges/tick, prescaler 5, f0 2
        measure(3'd1, 2'd0, 40,  "R3 window code 0");
        measure(3'd1, 2'd1, 80,  "R3 window code 1");
        measure(3'd1, 2'd2, 320, "R3 window code 2");
        measure(3'd1, 2'd3, 640, "R3 window code 3");
        measure(3'd7, 2'd1, 80,  "R4 code 7 picks IF");
        measure(3'd2, 2'd1, 40,  "R4 code 2 picks prescaler");
        measure(3'd3, 2'd1, 40,  "R4 code 3 picks prescaler");
        measure(3'd4, 2'd1, 16,  "R4 code 4 picks f0");
        measure(3'd5, 2'd1, 16,  "R4 code 5 picks f0");
        measure(3'd0, 2'd1, 0,   "R4 code 0 unused");
        measure(3'd1, 2'd0, 40,  "R3 window code 0 again");
        measure(3'd6, 2'd1, 0,   "R4 code 6 unused");

        // R5: read mid-run returns previous result
        prev = res();
        go(3'd1, 2'd3);
        repeat (200) @(negedge clk);
        check(busy && res() == prev, "R5 previous result during run", res(), prev);
        wait_done(p);
        check(res() == 640, "R5 new result after close", res(), 640);

        // R10: codes changed mid-run are not used
        go(3'd1, 2'd0);
        repeat (3) @(negedge clk);
        src_sel = 3'd4; gate_sel = 2'd3;
        wait_done(p);
        check(res() == 40, "R10 codes captured at trigger", res(), 40);

        // R8: retrigger while busy is ignored
        measure(3'd4, 2'd0, 8, "R4 f0 short window");
        go(3'd1, 2'd0);
        repeat (30) @(negedge clk);
        src_sel = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(p);
        check(res() == 40, "R8 retrigger while busy ignored", res(), 40);
        check(p == 1, "R8 single clear pulse", p, 1);
        repeat (5) @(negedge clk);
        check(!busy, "R8 no second run after retrigger", busy, 0);

        // R8: trigger with enable low is ignored
        en = 1'b0;
        go(3'd1, 2'd1);
        repeat (5) @(negedge clk);
        check(!busy, "R8 trigger while disabled ignored", busy, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && res() == 40, "R8 result untouched while disabled", res(), 40);

        // R9: abandon on enable drop
        prev = res();
        go(3'd1, 2'd2);
        repeat (50) @(negedge clk);
        en = 1'b0;
        wait_done(p);
        check(res() == prev, "R9 result kept on abort", res(), prev);
        check(p == 1, "R9 clear pulse on abort", p, 1);
        en = 1'b1;
        @(negedge clk);

        // R6: saturation with a long tick period (66000 edges in window)
        @(posedge clk);
        tick_per = 33000;
        tick_jump = 1'b1;
        go(3'd1, 2'd0);
        wait_done(p);
        check(res() == 65535, "R6 saturates at 0xFFFF", res(), 65535);
        check(count_lo == 8'hFF && count_hi == 8'hFF, "R5 byte split", {count_hi, count_lo}, 65535);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule